// File: doc/BRIEF.md
# Audio serial port clock generator

This block produces the three clocks of a stereo audio serial link: a master clock (MCLK) for the converter, a bit clock and a word-select (frame) clock. It runs in the system clock domain. Each of three source oscillators is presented as a one-cycle strobe, one strobe per edge of that source, and a select field picks the source in use. The block counts source edges to form MCLK, counts MCLK edges to form the bit clock, and counts bit-clock falling edges to form the word-select clock. Every output is a registered level, so duty cycle is exactly 50 % for every divide ratio, odd ones included.

Configuration arrives as a 13-bit format word. Its divisor fields use a non-linear code in which a few reserved values select odd ratios. A write lands in a holding register and becomes active only while the clocks are halted. When the enable is removed, the block runs on until MCLK and the bit clock are both low. It then suppresses the next rising edge and raises a sticky stopped flag, so that software can wait for a clean halt before it changes the format.

Top module: `i2s_clkgen`

## Requirements
- R1: Format bits [12:8] hold the MCLK code. 0x14 divides by 1, 0x13 by 3, 0x12 by 5, and any other code k divides by 2*(k+1). MCLK toggles once every that many edges of the selected source.
- R2: Format bits [7:4] hold the bit-clock code. 0x8 divides by 1, 0x9 by 3, and any other code k divides by 2*(k+1). The bit clock toggles once every that many MCLK toggles, so it changes only together with MCLK.
- R3: Format bits [3:2] pick the source strobe: 0, 1 or 2 selects `src_edge_i` bit 0, 1 or 2. The value 3 behaves as 2.
- R4: Format bit 1 picks the frame size: 0 gives 32 bit clocks per frame, 1 gives 64. The word-select clock toggles every half frame and changes only on a falling edge of the bit clock.
- R5: Format bit 0 set selects master mode, where `bclk_oe_o` is high. When it is clear, `bclk_oe_o` is low, `bclk_o` and `ws_o` stay low, and MCLK still runs.
- R6: After `en_i` falls, the clocks halt with `mclk_o` and `bclk_o` low. No high phase of MCLK is shortened. `stopped_o` rises on the clock edge where the halt happens, and the outputs stay frozen while `en_i` remains low.
- R7: A format write while the clocks run has no effect on the running ratios. It takes effect at the next start after a halt.
- R8: `stopped_o` is sticky. It is cleared by a pulse on `stop_clr_i` or by the start that follows a rise of `en_i`.
- R9: After reset all clock outputs and `stopped_o` are low. The active format is MCLK code 1, bit-clock code 1, source 0, 64-clock frames, master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_edge_i | input | 3 | One strobe per edge of each source oscillator |
| en_i | input | 1 | Clock run enable |
| fmt_we_i | input | 1 | Format word write strobe |
| fmt_i | input | 13 | Format word |
| stop_clr_i | input | 1 | Clears the stopped flag |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select clock |
| bclk_oe_o | output | 1 | Output enable for bit and word-select clocks (master mode) |
| stopped_o | output | 1 | Sticky clocks-halted flag |

## Verification
The bench uses the default field widths: a 5-bit MCLK code, a 4-bit bit-clock code and three sources, with a counter width of 7 bits. With these widths every special odd code can be reached, along with the linear codes up to the largest frame half of 32. Source 0 strobes on every cycle, so the divide ratios appear directly as toggle intervals in clock cycles. Sources 1 and 2 strobe every third and every second cycle, which makes the effect of the source select measurable, including the reserved select value.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;
  localparam int unsigned SRC_N  = 3;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned MDIV_W = 5;
  localparam int unsigned SDIV_W = 4;
  localparam int unsigned HALF_SHORT = 16;
  localparam int unsigned HALF_LONG  = 32;

  typedef struct packed {
    logic [MDIV_W-1:0] mdiv;
    logic [SDIV_W-1:0] sdiv;
    logic [SRC_W-1:0]  src;
    logic              fmt64;
    logic              master;
  } fmt_t;

  localparam int unsigned FMT_W = $bits(fmt_t);

  localparam fmt_t FMT_RST = '{mdiv: MDIV_W'(1), sdiv: SDIV_W'(1),
                               src: '0, fmt64: 1'b1, master: 1'b1};

  function automatic logic [MDIV_W+1:0] decode_mdiv(input logic [MDIV_W-1:0] c);
    logic [MDIV_W+1:0] r;
    case (c)
      MDIV_W'(8'h14): r = (MDIV_W+2)'(1);
      MDIV_W'(8'h13): r = (MDIV_W+2)'(3);
      MDIV_W'(8'h12): r = (MDIV_W+2)'(5);
      default:        r = ((MDIV_W+2)'(c) + (MDIV_W+2)'(1)) << 1;
    endcase
    return r;
  endfunction

  function automatic logic [SDIV_W+1:0] decode_sdiv(input logic [SDIV_W-1:0] c);
    logic [SDIV_W+1:0] r;
    case (c)
      SDIV_W'(8'h08): r = (SDIV_W+2)'(1);
      SDIV_W'(8'h09): r = (SDIV_W+2)'(3);
      default:        r = ((SDIV_W+2)'(c) + (SDIV_W+2)'(1)) << 1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2s_clkgen_div.sv
// Edge counter: pulses tog_o on every ratio_i-th tick.
module i2s_clkgen_div #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             tog_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap  = (cnt_q == ratio_i - CNT_W'(1));
  assign tog_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W = MDIV_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_edge_i,
  input  logic             en_i,
  input  logic             fmt_we_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic             stop_clr_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             bclk_oe_o,
  output logic             stopped_o
);
  localparam int unsigned STAGES = 3;  // mclk, bclk, ws

  fmt_t pend_q, cfg_q;
  logic run_q, mclk_q, bclk_q, ws_q, stopped_q;
  logic [SRC_W-1:0] src_idx;
  logic             src_ev, start, stop_now;

  logic [CNT_W-1:0] ratio [STAGES];
  logic [STAGES-1:0] tick, tog;

  assign src_idx = (cfg_q.src >= SRC_W'(SRC_N)) ? SRC_W'(SRC_N - 1) : cfg_q.src;
  assign src_ev  = src_edge_i[src_idx];

  assign ratio[0] = CNT_W'(decode_mdiv(cfg_q.mdiv));
  assign ratio[1] = CNT_W'(decode_sdiv(cfg_q.sdiv));
  assign ratio[2] = cfg_q.fmt64 ? CNT_W'(HALF_LONG) : CNT_W'(HALF_SHORT);

  assign start    = en_i & ~run_q;
  // halt in place of the next MCLK rising edge, both clocks low
  assign stop_now = run_q & ~en_i & tog[0] & ~mclk_q & ~bclk_q;

  assign tick[0] = run_q & src_ev;
  assign tick[1] = tog[0] & cfg_q.master & ~stop_now;
  assign tick[2] = tog[1] & bclk_q;  // bclk falling edge

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    i2s_clkgen_div #(.CNT_W(CNT_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (~run_q),
      .tick_i (tick[g]),
      .ratio_i(ratio[g]),
      .tog_o  (tog[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= FMT_RST;
      cfg_q  <= FMT_RST;
    end else begin
      if (fmt_we_i) pend_q <= fmt_t'(fmt_i);
      if (!run_q)   cfg_q  <= pend_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      mclk_q    <= 1'b0;
      bclk_q    <= 1'b0;
      ws_q      <= 1'b0;
      stopped_q <= 1'b0;
    end else begin
      if (start)         run_q <= 1'b1;
      else if (stop_now) run_q <= 1'b0;
      if (tog[0] && !stop_now) mclk_q <= ~mclk_q;
      if (tog[1]) bclk_q <= ~bclk_q;
      if (tog[2]) ws_q   <= ~ws_q;
      if (stop_now)                stopped_q <= 1'b1;
      else if (start || stop_clr_i) stopped_q <= 1'b0;
    end
  end

  assign mclk_o    = mclk_q;
  assign bclk_o    = bclk_q;
  assign ws_o      = ws_q & cfg_q.master;
  assign bclk_oe_o = cfg_q.master;
  assign stopped_o = stopped_q;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic mclk_o,
  input logic bclk_o,
  input logic ws_o,
  input logic bclk_oe_o,
  input logic stopped_o
);
  a_r2_bclk_with_mclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bclk_o) |-> !$stable(mclk_o));

  a_r4_ws_on_bclk_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> ($fell(bclk_o) || !$stable(bclk_oe_o)));

  a_r5_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_oe_o |-> (!bclk_o && !ws_o));

  a_r6_halt_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> (!mclk_o && !bclk_o));

  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && !en_i) |=> ($stable(mclk_o) && $stable(bclk_o)));
endmodule

bind i2s_clkgen i2s_clkgen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .mclk_o   (mclk_o),
  .bclk_o   (bclk_o),
  .ws_o     (ws_o),
  .bclk_oe_o(bclk_oe_o),
  .stopped_o(stopped_o)
);

// File: tb/sim_i2s_clkgen.sv
`timescale 1ns/1ps
module sim_i2s_clkgen;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  src;
  logic        en = 0, we = 0, clr = 0;
  logic [12:0] fmt = '0;
  logic        mclk, bclk, ws, oe, stopped;
  int checks = 0, errors = 0, cyc = 0, c3 = 0, c2 = 0;
  bit running = 0;

  always #5 clk = ~clk;

  i2s_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_edge_i(src), .en_i(en),
    .fmt_we_i(we), .fmt_i(fmt), .stop_clr_i(clr),
    .mclk_o(mclk), .bclk_o(bclk), .ws_o(ws), .bclk_oe_o(oe), .stopped_o(stopped)
  );

  // source strobes: every cycle, every third, every second
  always @(negedge clk) begin
    c3  <= (c3 == 2) ? 0 : c3 + 1;
    c2  <= (c2 == 1) ? 0 : c2 + 1;
  end
  assign src = {c2 == 0, c3 == 0, 1'b1};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic [12:0] mk(input [4:0] md, input [3:0] sd, input [1:0] s,
                               input f64, input ms);
    return {md, sd, s, f64, ms};
  endfunction

  function automatic logic sig(input int sel);
    return (sel == 0) ? mclk : (sel == 1) ? bclk : ws;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic halt();
    en = 0;
    if (running) while (!stopped) @(negedge clk);
    running = 0;
  endtask

  task automatic restart(input [12:0] f);
    halt();
    @(negedge clk); we = 1; fmt = f;
    @(negedge clk); we = 0; en = 1; running = 1;
    @(negedge clk);
  endtask

  task automatic meas(input int sel, output int n);
    logic prev;
    prev = sig(sel);
    while (sig(sel) == prev) @(negedge clk);
    prev = sig(sel); n = 0;
    while (sig(sel) == prev) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R9 mclk", mclk, 0); chk("R9 bclk", bclk, 0); chk("R9 ws", ws, 0);
    chk("R9 stopped", stopped, 0); chk("R9 oe", oe, 1);
  endtask

  task automatic t_mdiv();
    int n;
    int codes[6] = '{'h14, 'h13, 'h12, 0, 1, 6};
    int exps[6]  = '{1, 3, 5, 2, 4, 14};
    for (int i = 0; i < 6; i++) begin
      restart(mk(codes[i][4:0], 4'd1, 2'd0, 1'b1, 1'b1));
      meas(0, n); chk($sformatf("R1 mclk code %0h", codes[i]), n, exps[i]);
    end
  endtask

  task automatic t_sdiv();
    int n;
    restart(mk(5'h13, 4'h9, 2'd0, 1'b1, 1'b1)); meas(1, n); chk("R2 code 9", n, 9);
    restart(mk(5'd1, 4'h8, 2'd0, 1'b1, 1'b1));  meas(1, n); chk("R2 code 8", n, 4);
    restart(mk(5'h14, 4'd2, 2'd0, 1'b1, 1'b1)); meas(1, n); chk("R2 code 2", n, 6);
  endtask

  task automatic t_src();
    int n;
    restart(mk(5'd1, 4'd1, 2'd1, 1'b1, 1'b1)); meas(0, n); chk("R3 src1", n, 12);
    restart(mk(5'd1, 4'd1, 2'd2, 1'b1, 1'b1)); meas(0, n); chk("R3 src2", n, 8);
    restart(mk(5'd1, 4'd1, 2'd3, 1'b1, 1'b1)); meas(0, n); chk("R3 src3", n, 8);
  endtask

  task automatic t_frame();
    int n; logic pb, pw; int bad;
    restart(mk(5'h14, 4'h8, 2'd0, 1'b0, 1'b1)); meas(2, n); chk("R4 32x", n, 32);
    restart(mk(5'h14, 4'h8, 2'd0, 1'b1, 1'b1)); meas(2, n); chk("R4 64x", n, 64);
    restart(mk(5'd1, 4'd1, 2'd0, 1'b0, 1'b1));
    bad = 0; pb = bclk; pw = ws;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (ws != pw && !(pb && !bclk)) bad++;
      pb = bclk; pw = ws;
    end
    chk("R4 ws only on bclk fall", bad, 0);
  endtask

  task automatic t_slave();
    int bad = 0, tg = 0; logic pm;
    restart(mk(5'd1, 4'd1, 2'd0, 1'b1, 1'b0));
    chk("R5 oe low", oe, 0);
    pm = mclk;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk || ws) bad++;
      if (mclk != pm) tg++;
      pm = mclk;
    end
    chk("R5 bclk ws quiet", bad, 0);
    chk("R5 mclk runs", tg > 5, 1);
  endtask

  task automatic t_stop();
    int run_len = 0, bad_hi = 0, bad_lo = 0, moves = 0, phases = 0;
    logic pm;
    restart(mk(5'h13, 4'h9, 2'd0, 1'b1, 1'b1));
    repeat (40) @(negedge clk);
    en = 0; pm = mclk;
    while (!stopped) begin
      @(negedge clk); run_len++;
      if (mclk != pm) begin
        if (phases > 0 && pm == 1 && run_len != 3) bad_hi++;
        if (phases > 0 && pm == 0 && run_len < 3) bad_lo++;
        phases++; run_len = 0; pm = mclk;
      end
    end
    running = 0;
    chk("R6 mclk high phases full", bad_hi, 0);
    chk("R6 mclk low phases full", bad_lo, 0);
    chk("R6 mclk low at halt", mclk, 0);
    chk("R6 bclk low at halt", bclk, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (mclk || bclk) moves++;
    end
    chk("R6 frozen after halt", moves, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    chk("R8 stop_clr clears", stopped, 0);
    restart(mk(5'd1, 4'd1, 2'd0, 1'b1, 1'b1));
    halt();
    chk("R8 sticky", stopped, 1);
    repeat (5) @(negedge clk);
    chk("R8 still set", stopped, 1);
    en = 1; running = 1; @(negedge clk);
    chk("R8 enable clears", stopped, 0);
  endtask

  task automatic t_hold();
    int n;
    restart(mk(5'd1, 4'd1, 2'd0, 1'b1, 1'b1));
    @(negedge clk); we = 1; fmt = mk(5'h14, 4'd1, 2'd0, 1'b1, 1'b1);
    @(negedge clk); we = 0;
    meas(0, n); chk("R7 held while running", n, 4);
    halt();
    @(negedge clk); en = 1; running = 1;
    meas(0, n); chk("R7 applied after restart", n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mdiv();
    t_sdiv();
    t_src();
    t_frame();
    t_slave();
    t_stop();
    t_clear();
    t_hold();
    halt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule